// File: doc/BRIEF.md
# System Control Register File

This block holds the small set of privileged control registers that a simple 32-bit core consults when it handles traps and interrupts. Software reaches the registers through a register-number/select address: a combinational read port and a synchronous write port. Every register has its own write mask and its own reset value. Bits outside the mask, and registers that have no mask at all, cannot be changed by software.

On the hardware side, the block gathers six interrupt lines and shows them as pending bits in the cause register. It combines those bits with the status register's enable, mask and level bits to form one interrupt request for the core. A capture strobe records the exception code, the delay-slot flag and the return address, and raises the exception level. Two set/clear controls drive the exception-level and error-level bits directly. The trap entry address is formed continuously from the writable base register.

The block has no state machine. Its only sequential elements are the register cells, which load on reset or on a clock edge.

Top module: `sysctl_regs`

## Requirements
- R1: On reset the base register (number 15, select 1) holds 0x80000000. Every other register holds zero, so the interrupt request is low and the entry address is 0x80000180.
- R2: Register addresses (number/select) are: user-local 4/2, bad-address 8/0, count 9/0, compare 11/0, status 12/0, cause 13/0, return-PC 14/0, base 15/1 and config 16/0. Any other address reads as zero, and a write to it changes no register.
- R3: A write to the user-local or return-PC register replaces all 32 bits. A write to the base register replaces bits 31:2, and bits 1:0 always read as zero.
- R4: Writes to the bad-address, count, compare, cause and config registers have no effect.
- R5: In the status register, software can change only bit 0 (interrupt enable) and bits 15:8 (interrupt mask). Bit 1 (exception level), bit 2 (error level) and every other bit are left as they were.
- R6: Cause bits 15:8 show the live interrupt lines. Bit 10 is the transmit line (hardware line 0), bit 11 is the receive line (hardware line 1), bits 15:12 are ext_irq[3:0], and bits 9:8 read as zero.
- R7: core_irq is high, in the same cycle, exactly when all of the following hold: (cause[15:8] & status[15:8]) is nonzero, status bit 0 is set, status bit 1 is clear and status bit 2 is clear.
- R8: A pulse on exl_wr loads exl_val into status bit 1 at the next clock edge, and a pulse on erl_wr loads erl_val into status bit 2 in the same way.
- R9: On an exc_take pulse the block makes four updates. The return-PC register takes exc_pc, or exc_pc - 4 when exc_in_ds is set. Cause bit 31 takes exc_in_ds. Cause bits 6:2 take exc_code. Status bit 1 is set. The capture wins over a software write or an exl_wr in the same cycle.
- R10: vec_addr always equals the base register value plus 0x180.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_num | input | 5 | Register number for read and write |
| reg_sel | input | 3 | Register select for read and write |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 32 | Software write data |
| rd_data | output | 32 | Read data for the addressed register |
| tx_irq | input | 1 | Transmit interrupt, hardware line 0 |
| rx_irq | input | 1 | Receive interrupt, hardware line 1 |
| ext_irq | input | 4 | Hardware lines 2 to 5 |
| exl_wr | input | 1 | Load status exception level |
| exl_val | input | 1 | Value for exception level |
| erl_wr | input | 1 | Load status error level |
| erl_val | input | 1 | Value for error level |
| exc_take | input | 1 | Exception capture strobe |
| exc_code | input | 5 | Exception code to record |
| exc_pc | input | 32 | PC of the faulting instruction |
| exc_in_ds | input | 1 | Faulting instruction is in a delay slot |
| core_irq | output | 1 | Interrupt request to the core |
| vec_addr | output | 32 | Exception entry address |

## Verification
The hardest conditions to reach are the states where the interrupt lines are pending but the request must stay low because of the exception level or the error level. Software writes cannot set either bit, so the bench drives them through the set/clear controls. It then walks all eight enable/level combinations, each under several mask values and all 64 line patterns. Same-cycle collisions are also created deliberately: a capture arrives together with a software write to the return-PC register, and together with an exl_wr clear, so that the precedence of the capture is observed at the read port.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int XLEN    = 32;
    localparam int NREGS   = 9;
    localparam int PEND_W  = 8;

    // status / cause bit positions
    localparam int ST_IE   = 0;
    localparam int ST_EXL  = 1;
    localparam int ST_ERL  = 2;
    localparam int FLD_LO  = 8;   // mask and pending fields share 15:8
    localparam int CA_BD   = 31;
    localparam int CODE_LO = 2;
    localparam int CODE_W  = 5;

    typedef enum logic [3:0] {
        RI_ULOCAL  = 4'd0,
        RI_BADVA   = 4'd1,
        RI_COUNT   = 4'd2,
        RI_COMPARE = 4'd3,
        RI_STATUS  = 4'd4,
        RI_CAUSE   = 4'd5,
        RI_EPC     = 4'd6,
        RI_EBASE   = 4'd7,
        RI_CONFIG  = 4'd8,
        RI_NONE    = 4'd15
    } reg_idx_e;

    function automatic reg_idx_e addr_decode(input logic [4:0] num, input logic [2:0] sel);
        case ({num, sel})
            {5'd4,  3'd2}: return RI_ULOCAL;
            {5'd8,  3'd0}: return RI_BADVA;
            {5'd9,  3'd0}: return RI_COUNT;
            {5'd11, 3'd0}: return RI_COMPARE;
            {5'd12, 3'd0}: return RI_STATUS;
            {5'd13, 3'd0}: return RI_CAUSE;
            {5'd14, 3'd0}: return RI_EPC;
            {5'd15, 3'd1}: return RI_EBASE;
            {5'd16, 3'd0}: return RI_CONFIG;
            default:       return RI_NONE;
        endcase
    endfunction

    function automatic logic [XLEN-1:0] sw_mask(input reg_idx_e idx);
        case (idx)
            RI_ULOCAL, RI_EPC: return 32'hFFFF_FFFF;
            RI_EBASE:          return 32'hFFFF_FFFC;
            RI_STATUS:         return 32'h0000_FF01;
            default:           return 32'h0000_0000;
        endcase
    endfunction

    function automatic logic [XLEN-1:0] rst_value(input reg_idx_e idx, input logic [XLEN-1:0] base_rst);
        return (idx == RI_EBASE) ? base_rst : '0;
    endfunction

endpackage

// File: rtl/sysctl_cell.sv
module sysctl_cell #(
    parameter int              W       = 32,
    parameter logic [W-1:0]    SW_MASK = '0,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sw_we,
    input  logic [W-1:0] sw_data,
    input  logic [W-1:0] hw_mask,
    input  logic [W-1:0] hw_data,
    output logic [W-1:0] q
);

    logic [W-1:0] after_sw;
    logic [W-1:0] nxt;

    always_comb begin
        after_sw = q;
        if (sw_we)
            after_sw = (q & ~SW_MASK) | (sw_data & SW_MASK);
        // hardware updates take precedence on the bits they cover
        nxt = (after_sw & ~hw_mask) | (hw_data & hw_mask);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= RST_VAL;
        else
            q <= nxt;
    end

endmodule

// File: rtl/sysctl_irq.sv
module sysctl_irq #(
    parameter int PW = 8
) (
    input  logic [PW-1:0] pend,
    input  logic [PW-1:0] mask,
    input  logic          ie,
    input  logic          exl,
    input  logic          erl,
    output logic          req
);

    logic any_unmasked;

    always_comb begin
        any_unmasked = |(pend & mask);
        req          = any_unmasked && ie && !exl && !erl;
    end

endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
    import sysctl_pkg::*;
#(
    parameter logic [31:0] EBASE_RST = 32'h8000_0000,
    parameter logic [31:0] VEC_OFF   = 32'h0000_0180,
    parameter int          EXT_IRQS  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [4:0]          reg_num,
    input  logic [2:0]          reg_sel,
    input  logic                wr_en,
    input  logic [31:0]         wr_data,
    output logic [31:0]         rd_data,
    input  logic                tx_irq,
    input  logic                rx_irq,
    input  logic [EXT_IRQS-1:0] ext_irq,
    input  logic                exl_wr,
    input  logic                exl_val,
    input  logic                erl_wr,
    input  logic                erl_val,
    input  logic                exc_take,
    input  logic [4:0]          exc_code,
    input  logic [31:0]         exc_pc,
    input  logic                exc_in_ds,
    output logic                core_irq,
    output logic [31:0]         vec_addr
);

    localparam int PW = EXT_IRQS + 4;

    reg_idx_e          hit_idx;
    logic [XLEN-1:0]   regq    [NREGS];
    logic [XLEN-1:0]   hw_mask [NREGS];
    logic [XLEN-1:0]   hw_data [NREGS];
    logic [NREGS-1:0]  we_vec;
    logic [PW-1:0]     pend;
    logic [XLEN-1:0]   status_w;
    logic [XLEN-1:0]   ebase_w;
    logic [XLEN-1:0]   ret_pc;

    assign hit_idx  = addr_decode(reg_num, reg_sel);
    assign pend     = {ext_irq, rx_irq, tx_irq, 2'b00};
    assign status_w = regq[int'(RI_STATUS)];
    assign ebase_w  = regq[int'(RI_EBASE)];
    assign ret_pc   = exc_in_ds ? (exc_pc - 32'd4) : exc_pc;

    // hardware-side updates: capture, level controls
    always_comb begin
        for (int i = 0; i < NREGS; i++) begin
            hw_mask[i] = '0;
            hw_data[i] = '0;
        end
        if (exc_take || exl_wr) begin
            hw_mask[int'(RI_STATUS)][ST_EXL] = 1'b1;
            hw_data[int'(RI_STATUS)][ST_EXL] = exc_take | exl_val;
        end
        if (erl_wr) begin
            hw_mask[int'(RI_STATUS)][ST_ERL] = 1'b1;
            hw_data[int'(RI_STATUS)][ST_ERL] = erl_val;
        end
        if (exc_take) begin
            hw_mask[int'(RI_EPC)] = '1;
            hw_data[int'(RI_EPC)] = ret_pc;
            hw_mask[int'(RI_CAUSE)][CA_BD] = 1'b1;
            hw_data[int'(RI_CAUSE)][CA_BD] = exc_in_ds;
            hw_mask[int'(RI_CAUSE)][CODE_LO +: CODE_W] = '1;
            hw_data[int'(RI_CAUSE)][CODE_LO +: CODE_W] = exc_code;
        end
    end

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        localparam logic [XLEN-1:0] M = sw_mask(reg_idx_e'(g));
        localparam logic [XLEN-1:0] R = rst_value(reg_idx_e'(g), EBASE_RST);

        assign we_vec[g] = wr_en && (hit_idx == reg_idx_e'(g));

        sysctl_cell #(
            .W       (XLEN),
            .SW_MASK (M),
            .RST_VAL (R)
        ) u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .sw_we   (we_vec[g]),
            .sw_data (wr_data),
            .hw_mask (hw_mask[g]),
            .hw_data (hw_data[g]),
            .q       (regq[g])
        );
    end

    // read mux; cause shows live pending lines in 15:8
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NREGS; i++) begin
            if (hit_idx == reg_idx_e'(i))
                rd_data = regq[i];
        end
        if (hit_idx == RI_CAUSE)
            rd_data[FLD_LO +: PW] = rd_data[FLD_LO +: PW] | pend;
    end

    sysctl_irq #(.PW(PW)) u_irq (
        .pend (pend),
        .mask (status_w[FLD_LO +: PW]),
        .ie   (status_w[ST_IE]),
        .exl  (status_w[ST_EXL]),
        .erl  (status_w[ST_ERL]),
        .req  (core_irq)
    );

    assign vec_addr = ebase_w + VEC_OFF;

endmodule

// File: rtl/sysctl_regs_chk.sv
module sysctl_regs_chk #(
    parameter logic [31:0] VEC_OFF = 32'h0000_0180
) (
    input logic        clk,
    input logic        rst_n,
    input logic [4:0]  reg_num,
    input logic [2:0]  reg_sel,
    input logic [31:0] rd_data,
    input logic [31:0] vec_addr,
    input logic        core_irq,
    input logic        exc_take,
    input logic        exl_wr,
    input logic        exl_val,
    input logic        erl_wr,
    input logic        erl_val,
    input logic [31:0] status_w,
    input logic [31:0] ebase_w
);

    p_vec_follows_base_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_num == 5'd15 && reg_sel == 3'd1) |-> (vec_addr == rd_data + VEC_OFF));

    p_irq_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        core_irq |-> (status_w[0] && !status_w[1] && !status_w[2]));

    p_capture_sets_exl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        exc_take |=> status_w[1]);

    p_exl_control_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (exl_wr && !exc_take) |=> (status_w[1] == $past(exl_val)));

    p_erl_control_r8: assert property (@(posedge clk) disable iff (!rst_n)
        erl_wr |=> (status_w[2] == $past(erl_val)));

    p_status_fixed_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (status_w & ~32'h0000_FF07) == 32'h0);

    p_base_low_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ebase_w[1:0] == 2'b00);

endmodule

bind sysctl_regs sysctl_regs_chk #(.VEC_OFF(VEC_OFF)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_num  (reg_num),
    .reg_sel  (reg_sel),
    .rd_data  (rd_data),
    .vec_addr (vec_addr),
    .core_irq (core_irq),
    .exc_take (exc_take),
    .exl_wr   (exl_wr),
    .exl_val  (exl_val),
    .erl_wr   (erl_wr),
    .erl_val  (erl_val),
    .status_w (status_w),
    .ebase_w  (ebase_w)
);

// File: tb/sysctl_regs_test.sv
`timescale 1ns/1ps
module sysctl_regs_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  reg_num;
    logic [2:0]  reg_sel;
    logic        wr_en;
    logic [31:0] wr_data;
    logic [31:0] rd_data;
    logic        tx_irq, rx_irq;
    logic [3:0]  ext_irq;
    logic        exl_wr, exl_val, erl_wr, erl_val;
    logic        exc_take;
    logic [4:0]  exc_code;
    logic [31:0] exc_pc;
    logic        exc_in_ds;
    logic        core_irq;
    logic [31:0] vec_addr;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit done   = 0;

    logic [31:0] model [256];

    always #10 clk = ~clk;   // 50 MHz

    sysctl_regs uut (
        .clk(clk), .rst_n(rst_n), .reg_num(reg_num), .reg_sel(reg_sel),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .tx_irq(tx_irq), .rx_irq(rx_irq), .ext_irq(ext_irq),
        .exl_wr(exl_wr), .exl_val(exl_val), .erl_wr(erl_wr), .erl_val(erl_val),
        .exc_take(exc_take), .exc_code(exc_code), .exc_pc(exc_pc),
        .exc_in_ds(exc_in_ds), .core_irq(core_irq), .vec_addr(vec_addr)
    );

    function automatic logic [31:0] mask_of(input logic [7:0] a);
        case (a)
            {5'd4,  3'd2}, {5'd14, 3'd0}: return 32'hFFFF_FFFF;
            {5'd15, 3'd1}:                return 32'hFFFF_FFFC;
            {5'd12, 3'd0}:                return 32'h0000_FF01;
            default:                      return 32'h0;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
        end
    endtask

    task automatic rd(input logic [4:0] n, input logic [2:0] s, output logic [31:0] v);
        reg_num = n; reg_sel = s; #1; v = rd_data;
    endtask

    task automatic wr(input logic [4:0] n, input logic [2:0] s, input logic [31:0] d);
        @(negedge clk);
        reg_num = n; reg_sel = s; wr_data = d; wr_en = 1'b1;
        @(posedge clk); #2;
        wr_en = 1'b0;
        model[{n, s}] = (model[{n, s}] & ~mask_of({n, s})) | (d & mask_of({n, s}));
    endtask

    task automatic set_levels(input logic exl, input logic erl);
        @(negedge clk);
        exl_wr = 1'b1; exl_val = exl; erl_wr = 1'b1; erl_val = erl;
        @(posedge clk); #2;
        exl_wr = 1'b0; erl_wr = 1'b0;
    endtask

    task automatic sweep_check(input string tag);
        logic [31:0] v;
        for (int a = 0; a < 256; a++) begin
            rd(a[7:3], a[2:0], v);
            chk(tag, v, model[a], $sformatf("readback of %0d/%0d", a[7:3], a[2:0]));
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [7:0]  ims [5];
        ims[0] = 8'hFF; ims[1] = 8'h04; ims[2] = 8'h08; ims[3] = 8'hF0; ims[4] = 8'h03;

        rst_n = 1'b0; reg_num = '0; reg_sel = '0; wr_en = 1'b0; wr_data = '0;
        tx_irq = 1'b0; rx_irq = 1'b0; ext_irq = '0;
        exl_wr = 1'b0; exl_val = 1'b0; erl_wr = 1'b0; erl_val = 1'b0;
        exc_take = 1'b0; exc_code = '0; exc_pc = '0; exc_in_ds = 1'b0;
        for (int a = 0; a < 256; a++) model[a] = 32'h0;
        model[{5'd15, 3'd1}] = 32'h8000_0000;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        // R1: reset values on every address, request, entry address
        sweep_check("R1");
        chk("R1", {31'b0, core_irq}, 32'h0, "core_irq after reset");
        chk("R1", vec_addr, 32'h8000_0180, "entry address after reset");

        // R2 R3 R4 R5: all-ones to every address, then full readback
        for (int a = 0; a < 256; a++) wr(a[7:3], a[2:0], 32'hFFFF_FFFF);
        sweep_check("R2/R3/R4/R5 ones");
        chk("R10", vec_addr, 32'hFFFF_FFFC + 32'h180, "entry address after ones");
        for (int a = 0; a < 256; a++) wr(a[7:3], a[2:0], {a[7:0], ~a[7:0], a[7:0] ^ 8'h5A, ~a[7:0]});
        sweep_check("R2/R3/R4/R5 pattern");
        for (int a = 0; a < 256; a++) wr(a[7:3], a[2:0], 32'h0);
        sweep_check("R2/R3/R4/R5 zeros");

        // R6 R7 R8: every IE/EXL/ERL combination, several masks, all line patterns
        for (int c = 0; c < 8; c++) begin
            set_levels(c[1], c[2]);
            for (int m = 0; m < 5; m++) begin
                wr(5'd12, 3'd0, {16'h0, ims[m], 7'h0, c[0]});
                rd(5'd12, 3'd0, v);
                chk("R8", v, {16'h0, ims[m], 5'h0, c[2], c[1], c[0]}, "status levels");
                for (int l = 0; l < 64; l++) begin
                    logic [7:0] pnd;
                    logic       exp_irq;
                    {ext_irq, rx_irq, tx_irq} = l[5:0];
                    pnd = {l[5:0], 2'b00};
                    exp_irq = (|(pnd & ims[m])) && c[0] && !c[1] && !c[2];
                    rd(5'd13, 3'd0, v);
                    chk("R6", v, {16'h0, pnd, 8'h0}, "cause pending");
                    chk("R7", {31'b0, core_irq}, {31'b0, exp_irq}, "core_irq gating");
                end
            end
        end
        ext_irq = '0; rx_irq = 1'b0; tx_irq = 1'b1;
        set_levels(1'b0, 1'b0);
        wr(5'd12, 3'd0, 32'h0000_FF01);
        chk("R7", {31'b0, core_irq}, 32'h1, "transmit line requests");

        // R9: capture beats same-cycle software write to return-PC
        @(negedge clk);
        exc_take = 1'b1; exc_code = 5'd12; exc_pc = 32'h0040_0020; exc_in_ds = 1'b0;
        reg_num = 5'd14; reg_sel = 3'd0; wr_data = 32'h0000_1234; wr_en = 1'b1;
        @(posedge clk); #2;
        exc_take = 1'b0; wr_en = 1'b0;
        rd(5'd14, 3'd0, v); chk("R9", v, 32'h0040_0020, "return PC no slot");
        rd(5'd13, 3'd0, v); chk("R9", v, 32'h0000_0430, "cause code no slot");
        rd(5'd12, 3'd0, v); chk("R9", v, 32'h0000_FF03, "status level raised");
        chk("R7", {31'b0, core_irq}, 32'h0, "request held off by level");
        set_levels(1'b0, 1'b0);
        chk("R8", {31'b0, core_irq}, 32'h1, "request back after level clear");

        // R9: delay slot, capture beats same-cycle exl clear
        @(negedge clk);
        exc_take = 1'b1; exc_code = 5'd4; exc_pc = 32'h0000_1000; exc_in_ds = 1'b1;
        exl_wr = 1'b1; exl_val = 1'b0;
        @(posedge clk); #2;
        exc_take = 1'b0; exl_wr = 1'b0; exc_in_ds = 1'b0;
        rd(5'd14, 3'd0, v); chk("R9", v, 32'h0000_0FFC, "return PC in slot");
        rd(5'd13, 3'd0, v); chk("R9", v, 32'h8000_0410, "cause slot flag and code");
        rd(5'd12, 3'd0, v); chk("R9", v, 32'h0000_FF03, "capture wins over exl clear");
        wr(5'd13, 3'd0, 32'h0000_0000);
        rd(5'd13, 3'd0, v); chk("R4", v, 32'h8000_0410, "cause unchanged by write");

        // R10 R3: entry address after rewriting the base
        wr(5'd15, 3'd1, 32'h9FC0_0000);
        chk("R10", vec_addr, 32'h9FC0_0180, "entry address base A");
        wr(5'd15, 3'd1, 32'hBFC0_0003);
        rd(5'd15, 3'd1, v); chk("R3", v, 32'hBFC0_0000, "base low bits dropped");
        chk("R10", vec_addr, 32'hBFC0_0180, "entry address base B");
        wr(5'd15, 3'd1, 32'h0000_0000);
        chk("R10", vec_addr, 32'h0000_0180, "entry address base zero");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule